// File: doc/BRIEF.md
# SPI Register-Access Slave

This block sits between an external SPI master and a 21-entry register space held elsewhere on the chip. It oversamples the serial clock, select and data lines in the system clock domain. It decodes a leading command byte and turns each later byte in the same select window into a one-cycle write strobe or read strobe on a simple parallel register port. Both idle-low and idle-high clock polarities are accepted, provided data is sampled on the rising edge and changed on the falling edge.

The low five register numbers are FIFO windows: every byte in a transfer stays on the commanded address. Higher numbers are control registers, and the address steps forward after each byte until it sticks at the last one. In the normal four-wire arrangement, a status byte supplied by the surrounding logic is returned on the data-out line while the command goes in. A strap selects a three-wire arrangement, in which the data-out line is never driven and read data is returned on the data-in line.

Top module: `spi_regif_slave`

## Requirements
- R1: The command byte, sent MSB first, carries the register number in bits 7..3 and the direction in bit 1 (1 = write, 0 = read). Bit 0 is the acknowledge flag, and the value of bit 2 has no effect.
- R2: A transfer runs from the falling edge of `ss_n_i` to its rising edge. Clock edges while `ss_n_i` is high cause no strobe and no state change.
- R3: Input bits are taken on rising `sclk_i` edges and output bits change on falling edges, MSB first. This holds for idle-low (mode 0) and idle-high (mode 3) clocks alike.
- R4: In four-wire mode `miso_oe_o` is high only while selected, and the first byte shifted out is `status_i` as captured at the start of the transfer.
- R5: For register numbers 0 to 4, every data byte of the transfer uses the commanded address.
- R6: For register numbers 5 to 20, the address goes up by one after each data byte and stays at 20 once it gets there.
- R7: For register numbers 21 to 31, no write or read strobe is given and every returned data byte is 0x00.
- R8: Each completed data byte of a write transfer gives one single-cycle `reg_wr_o` pulse, with the current address on `reg_addr_o` and the byte on `reg_wdata_o`.
- R9: In a read transfer, `reg_rd_o` samples `reg_rdata_i` (combinational on `reg_addr_o`) once per byte slot. The value is shifted out as the next byte, and the next slot is fetched ahead of time.
- R10: A command byte with bit 0 set gives exactly one single-cycle `ack_set_o` pulse.
- R11: In three-wire mode `miso_oe_o` stays low. On a read, `mosi_oe_o` rises after the eighth rising clock edge, the data appears on `mosi_o`, and `mosi_oe_o` falls when select is released.
- R12: If select is released part-way through a byte, the partial byte is discarded with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_duplex_i | input | 1 | 1 = three-wire mode, static |
| sclk_i | input | 1 | SPI serial clock |
| ss_n_i | input | 1 | SPI select, active low |
| mosi_i | input | 1 | Serial data in |
| mosi_o | output | 1 | Read data driven onto the data-in line in three-wire mode |
| mosi_oe_o | output | 1 | Output enable for `mosi_o` |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| status_i | input | 8 | Status byte returned during the command byte |
| reg_addr_o | output | 5 | Register address |
| reg_wr_o | output | 1 | Write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | Read strobe (FIFO pop) |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |
| ack_set_o | output | 1 | Pulse that sets the acknowledge-status bit |

## Verification
A wrong step of the address counter appears as a wrong `reg_addr_o` on the write strobe that follows the next completed byte. It also appears as wrong read data within one byte time, so sweeping every register number with multi-byte transfers exposes the FIFO/control/saturation split. A stale output register or a missed load shows up as a wrong first bit of the next byte. A lost rising edge shifts every later byte by one bit. A late enable on the turned-around line is seen at the first data bit of a three-wire read.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int unsigned AW        = 5;
  localparam int unsigned FIFO_LAST = 4;
  localparam int unsigned REG_LAST  = 20;

  // Address after one data byte: FIFO ports hold, control registers
  // advance and saturate, out-of-range numbers are left as they are.
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    if (a <= AW'(FIFO_LAST)) return a;
    else if (a < AW'(REG_LAST)) return a + AW'(1);
    else return a;
  endfunction

  function automatic logic addr_ok(input logic [AW-1:0] a);
    return a <= AW'(REG_LAST);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= din;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_rx_byte.sv
module spi_rx_byte #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift_en,
  input  logic          din,
  output logic          byte_done,
  output logic [DW-1:0] byte_val
);
  localparam int unsigned CW = $clog2(DW);

  logic [DW-2:0] sh;
  logic [CW-1:0] cnt;

  assign byte_done = shift_en && (cnt == CW'(DW-1));
  assign byte_val  = {sh, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift_en) begin
      sh  <= {sh[DW-3:0], din};
      cnt <= byte_done ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/spi_tx_byte.sv
module spi_tx_byte #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_now,
  input  logic [DW-1:0] load_val,
  input  logic          stage_en,
  input  logic [DW-1:0] stage_val,
  input  logic          rise,
  input  logic          fall,
  output logic          dout
);
  logic [DW-1:0] tx;
  logic [DW-1:0] pend;
  logic          pend_v;
  logic          rose;

  assign dout = tx[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx     <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
      rose   <= 1'b0;
    end else if (load_now) begin
      tx     <= load_val;
      pend_v <= 1'b0;
      rose   <= 1'b0;
    end else begin
      if (rise) rose <= 1'b1;
      if (fall) begin
        rose <= 1'b0;
        if (pend_v) begin
          tx     <= pend;
          pend_v <= 1'b0;
        end else if (rose) begin
          tx <= {tx[DW-2:0], 1'b0};
        end
      end
      if (stage_en) begin
        pend   <= stage_val;
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_regif_slave.sv
module spi_regif_slave
  import spi_regif_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_duplex_i,
  input  logic          sclk_i,
  input  logic          ss_n_i,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe_o,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic [DW-1:0] status_i,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_wr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_rd_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          ack_set_o
);
  logic [2:0] pins_s;
  logic       sclk_s, ss_s, mosi_s;
  logic       sclk_d, ss_d;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({mosi_i, ss_n_i, sclk_i}),
    .dout(pins_s)
  );
  assign {mosi_s, ss_s, sclk_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      ss_d   <= ss_s;
    end
  end

  // Named events, also observed by the checker.
  logic sel_active, sel_start, sel_end, sclk_rise, sclk_fall;
  assign sel_active = !ss_s;
  assign sel_start  = ss_d && !ss_s;
  assign sel_end    = !ss_d && ss_s;
  assign sclk_rise  = sel_active && !sclk_d && sclk_s;
  assign sclk_fall  = sel_active && sclk_d && !sclk_s;

  logic          byte_done;
  logic [DW-1:0] rx_byte;

  spi_rx_byte #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .clear(sel_start || sel_end),
    .shift_en(sclk_rise),
    .din(mosi_s),
    .byte_done(byte_done),
    .byte_val(rx_byte)
  );

  logic          in_data, dir_wr, rd_q, wr_q, ack_q, hd_drive;
  logic [AW-1:0] addr_q, wr_addr_q;
  logic [DW-1:0] wdata_q;
  logic [AW-1:0] cmd_addr;
  logic          cmd_wr, cmd_ack;
  logic [AW-1:0] addr_next;

  assign cmd_addr  = rx_byte[DW-1 -: AW];
  assign cmd_wr    = rx_byte[1];
  assign cmd_ack   = rx_byte[0];
  assign addr_next = step_addr(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data   <= 1'b0;
      dir_wr    <= 1'b0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      ack_q     <= 1'b0;
      hd_drive  <= 1'b0;
      addr_q    <= '0;
      wr_addr_q <= '0;
      wdata_q   <= '0;
    end else begin
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      ack_q <= 1'b0;
      if (sel_start || sel_end) begin
        in_data  <= 1'b0;
        hd_drive <= 1'b0;
      end else if (byte_done) begin
        if (!in_data) begin
          in_data  <= 1'b1;
          addr_q   <= cmd_addr;
          dir_wr   <= cmd_wr;
          ack_q    <= cmd_ack;
          rd_q     <= !cmd_wr && addr_ok(cmd_addr);
          hd_drive <= half_duplex_i && !cmd_wr;
        end else if (dir_wr) begin
          wr_q      <= addr_ok(addr_q);
          wr_addr_q <= addr_q;
          wdata_q   <= rx_byte;
          addr_q    <= addr_next;
        end else begin
          addr_q <= addr_next;
          rd_q   <= addr_ok(addr_next);
        end
      end
    end
  end

  logic tx_bit;

  spi_tx_byte #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load_now(sel_start),
    .load_val(status_i),
    .stage_en(byte_done || rd_q),
    .stage_val(rd_q ? reg_rdata_i : '0),
    .rise(sclk_rise),
    .fall(sclk_fall),
    .dout(tx_bit)
  );

  assign reg_addr_o  = wr_q ? wr_addr_q : addr_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_rd_o    = rd_q;
  assign ack_set_o   = ack_q;
  assign miso_o      = tx_bit;
  assign miso_oe_o   = sel_active && !half_duplex_i;
  assign mosi_o      = tx_bit;
  assign mosi_oe_o   = sel_active && hd_drive;
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       half_duplex_i,
  input logic       miso_oe_o,
  input logic       mosi_oe_o,
  input logic       reg_wr_o,
  input logic       reg_rd_o,
  input logic [4:0] reg_addr_o,
  input logic       ack_set_o,
  input logic       sel_active,
  input logic       byte_done,
  input logic       in_data
);
  assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> reg_addr_o <= 5'd20);

  assert_rd_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |-> reg_addr_o <= 5'd20);

  assert_hd_miso_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    half_duplex_i |-> !miso_oe_o);

  assert_single_driver_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(miso_oe_o && mosi_oe_o));

  assert_wr_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  assert_ack_after_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_set_o |-> $past(byte_done && !in_data));

  assert_rd_while_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |-> $past(sel_active));

  assert_no_rw_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_o && reg_wr_o));
endmodule

bind spi_regif_slave spi_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .half_duplex_i(half_duplex_i),
  .miso_oe_o(miso_oe_o), .mosi_oe_o(mosi_oe_o),
  .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o), .reg_addr_o(reg_addr_o),
  .ack_set_o(ack_set_o), .sel_active(sel_active),
  .byte_done(byte_done), .in_data(in_data)
);

// File: tb/spi_regif_slave_tb.sv
module spi_regif_slave_tb;
  localparam int HALF = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_duplex_i = 1'b0;
  logic       sclk_i = 1'b0;
  logic       ss_n_i = 1'b1;
  logic       mosi_i = 1'b0;
  logic       mosi_o, mosi_oe_o, miso_o, miso_oe_o;
  logic [7:0] status_i = 8'h00;
  logic [4:0] reg_addr_o;
  logic       reg_wr_o, reg_rd_o, ack_set_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;

  int tests = 0, fails = 0;
  int wn = 0, rn = 0, an = 0;
  int miso_in_hd = 0;
  logic [4:0] wlog_a [16];
  logic [7:0] wlog_d [16];
  logic [7:0] mtx [16];
  logic [7:0] mrx [16];
  int oe_bad = 0;
  bit cpol = 0;
  bit rd_xfer = 0;

  always #2 clk = ~clk;

  spi_regif_slave u_dut (
    .clk(clk), .rst_n(rst_n), .half_duplex_i(half_duplex_i),
    .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .status_i(status_i), .reg_addr_o(reg_addr_o),
    .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o),
    .reg_rd_o(reg_rd_o), .reg_rdata_i(reg_rdata_i),
    .ack_set_o(ack_set_o)
  );

  function automatic logic [7:0] mval(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  function automatic int nxt(input int a);
    if (a < 5) return a;
    if (a < 20) return a + 1;
    return a;
  endfunction

  always_comb reg_rdata_i = (reg_addr_o <= 5'd20) ? mval(int'(reg_addr_o)) : 8'hEE;

  always @(negedge clk) begin
    if (reg_wr_o) begin
      if (wn < 16) begin
        wlog_a[wn] = reg_addr_o;
        wlog_d[wn] = reg_wdata_o;
      end
      wn++;
    end
    if (reg_rd_o) rn++;
    if (ack_set_o) an++;
    if (half_duplex_i && miso_oe_o) miso_in_hd++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int nbytes, input int extra);
    oe_bad = 0;
    sclk_i = cpol;
    #HALF;
    ss_n_i = 1'b0;
    #HALF;
    for (int b = 0; b < nbytes + 1; b++) begin
      logic [7:0] rcv;
      int nb;
      rcv = 8'h00;
      nb = (b == nbytes) ? extra : 8;
      for (int i = 7; i > 7 - nb; i--) begin
        if (cpol) sclk_i = 1'b0;
        mosi_i = (b == nbytes) ? 1'b1 : mtx[b][i];
        #HALF;
        rcv[i] = half_duplex_i ? mosi_o : miso_o;
        if (b > 0 && rd_xfer && half_duplex_i && !mosi_oe_o) oe_bad++;
        if (!half_duplex_i && !miso_oe_o) oe_bad++;
        sclk_i = 1'b1;
        #HALF;
        if (!cpol) sclk_i = 1'b0;
      end
      if (b < nbytes) mrx[b] = rcv;
    end
    #HALF;
    ss_n_i = 1'b1;
    #(HALF * 4);
  endtask

  initial begin
    #700000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #21;
    chk(miso_oe_o == 0 && mosi_oe_o == 0, "R2 reset oe", {miso_oe_o, mosi_oe_o}, 0);
    chk(reg_wr_o == 0 && reg_rd_o == 0 && ack_set_o == 0, "R2 reset strobes",
        {reg_wr_o, reg_rd_o, ack_set_o}, 0);
    rst_n = 1'b1;
    #40;

    // Write sweep over every register number, both clock polarities (R1 R5 R6 R7 R8 R10 R3 R4)
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 24; a++) begin
        int e, an0;
        cpol = p[0];
        rd_xfer = 0;
        status_i = 8'(a * 11 + p);
        mtx[0] = {5'(a), (a % 3 == 0) ? 1'b1 : 1'b0, 1'b1, a[0]};
        for (int k = 1; k < 4; k++) mtx[k] = 8'(a * 3 + k + p * 64);
        wn = 0; an0 = an;
        xfer(4, 0);
        chk(mrx[0] == status_i, "R4 status byte", mrx[0], status_i);
        chk(oe_bad == 0, "R4 miso_oe while selected", oe_bad, 0);
        chk(miso_oe_o == 0, "R4 miso released", miso_oe_o, 0);
        chk(an - an0 == int'(a[0]), "R10 ack pulse", an - an0, a[0]);
        if (a > 20) begin
          chk(wn == 0, "R7 no write out of range", wn, 0);
        end else begin
          chk(wn == 3, "R8 write count", wn, 3);
          e = a;
          for (int k = 1; k < 4; k++) begin
            chk(int'(wlog_a[k-1]) == e, (a < 5) ? "R5 fifo addr" : "R6 ctrl addr",
                wlog_a[k-1], e);
            chk(wlog_d[k-1] == mtx[k], "R8 R3 write data", wlog_d[k-1], mtx[k]);
            e = nxt(e);
          end
        end
      end
    end

    // Read sweep, both wire modes (R9 R11 R7 R5 R6 R3)
    for (int h = 0; h < 2; h++) begin
      for (int a = 0; a < 24; a++) begin
        int e, rn0;
        half_duplex_i = h[0];
        cpol = a[0];
        rd_xfer = 1;
        mtx[0] = {5'(a), 3'b000};
        for (int k = 1; k < 4; k++) mtx[k] = 8'hFF;
        rn0 = rn;
        miso_in_hd = 0;
        xfer(4, 0);
        e = a;
        for (int k = 1; k < 4; k++) begin
          logic [7:0] x;
          x = (a <= 20) ? mval(e) : 8'h00;
          chk(mrx[k] == x, (a > 20) ? "R7 read zero" : "R9 read data", mrx[k], x);
          e = nxt(e);
        end
        chk(rn - rn0 == ((a <= 20) ? 4 : 0), "R9 read strobes", rn - rn0, (a <= 20) ? 4 : 0);
        if (h == 1) begin
          chk(oe_bad == 0, "R11 mosi_oe during data", oe_bad, 0);
          chk(miso_in_hd == 0, "R11 miso never driven", miso_in_hd, 0);
          chk(mosi_oe_o == 0, "R11 mosi released", mosi_oe_o, 0);
        end
      end
    end
    half_duplex_i = 1'b0;
    rd_xfer = 0;

    // Clock toggling while deselected (R2)
    wn = 0; rn = 0;
    for (int i = 0; i < 24; i++) begin
      mosi_i = i[1];
      sclk_i = ~sclk_i;
      #HALF;
    end
    chk(wn == 0 && rn == 0, "R2 deselected clocks ignored", wn + rn, 0);
    chk(miso_oe_o == 0, "R2 miso off while deselected", miso_oe_o, 0);

    // Partial byte (R12)
    cpol = 0;
    sclk_i = 1'b0;
    mtx[0] = {5'd6, 3'b010};
    mtx[1] = 8'h5C;
    wn = 0;
    xfer(2, 5);
    chk(wn == 1, "R12 partial byte dropped", wn, 1);
    chk(wlog_d[0] == 8'h5C && wlog_a[0] == 5'd6, "R12 full byte kept", wlog_d[0], 8'h5C);
    wn = 0;
    mtx[0] = {5'd9, 3'b010};
    mtx[1] = 8'hA1;
    xfer(2, 0);
    chk(wn == 1 && wlog_a[0] == 5'd9, "R12 next transfer aligned", wlog_a[0], 9);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule